// File: doc/BRIEF.md
# Dual-Rate Single-Wire LED Bit Encoder

This block turns a stream of bytes into the pulse-width waveform used by chains of addressable LEDs. Each bit begins with a rising edge on the data line. The bit value is carried by how long the line stays high inside a fixed bit period. A short high time means zero and a long high time means one. Two bit rates are available. All thresholds are whole clock-cycle counts, each the truncated quotient of the system clock divided by a target frequency. The default system clock is 48 MHz.

Bytes arrive over a valid/ready handshake that carries an end-of-frame marker on the final byte. The first byte is taken while the encoder is idle, and its first rising edge follows at once. Each later byte is fetched at one point only: the clock edge on which the final bit of the byte being sent starts. That byte is held until the current byte is finished, so bit periods run back to back across byte boundaries. The frame finishes when the full period of its last bit has elapsed. At that point the encoder raises a one-cycle completion pulse. The long latch gap between frames is left to the surrounding logic.

Top module: `ledwire_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, the data line and the busy and done outputs are low. The ready output is high in that state.
- R2: With the rate input low (fast rate), each bit period is 60 cycles. A 0 bit is high for 12 cycles and a 1 bit is high for 38 cycles.
- R3: With the rate input high (slow rate), each bit period is 120 cycles. A 0 bit is high for 24 cycles and a 1 bit is high for 57 cycles.
- R4: Bytes are sent in the order they are accepted. Each byte is sent as 8 bits, most-significant bit first.
- R5: A byte accepted while idle starts its first bit at once. The line is high in the cycle that follows the accepting clock edge, with no wait before it.
- R6: Rising edges within a frame are exactly one bit period apart, including across byte boundaries.
- R7: While a frame is in progress, ready is high for exactly one cycle per byte: the cycle just before the rising edge of that byte's final bit. Ready stays low there if the current byte carries the end-of-frame marker.
- R8: Done is a one-cycle pulse. It is seen exactly one bit period after the last rising edge of the frame, and busy falls with it. Busy is high at every rising edge of the frame.
- R9: The rate input is sampled when a frame starts. Changing it during the frame has no effect on that frame's timing.
- R10: If no byte is offered at a fetch point and the current byte is not marked last, the underrun output goes high. The frame then ends after the current byte, with its normal done pulse. The underrun flag stays high until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_slow | input | 1 | Rate select: 0 fast, 1 slow; sampled at frame start |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte on in_data is offered |
| in_last | input | 1 | Offered byte is the final one of the frame |
| in_ready | output | 1 | Encoder takes the offered byte on this clock edge |
| line_out | output | 1 | Serial data line to the LED chain |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame's final period has elapsed |
| underrun | output | 1 | No byte was offered at a fetch point of an open frame |

## Verification
The hardest situation to reach is the fetch point. Ready is high for a single cycle, buried deep inside each byte, and the rising edge that follows it must land exactly one period after the previous one. The bench keeps the next byte offered early, so the handshake happens at that single cycle. It logs the cycle of every ready pulse and every rising edge, and checks that each ready pulse sits one cycle before the final bit of its byte. Underrun is reached by marking a single byte as not last and then offering nothing more. The rate-change case switches the rate input right after the first byte is accepted.

// File: rtl/ledwire_pkg.sv
// Package ledwire_pkg
// Shared types and helpers for the single-wire LED encoder.
// Assumes all timings are whole clock-cycle counts derived by truncating division.
package ledwire_pkg;

    // Top-level sequencing state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } enc_state_t;

    // Truncated number of clock cycles in one period of rate_hz.
    function automatic int unsigned cycles_for(int unsigned clk_hz, int unsigned rate_hz);
        return clk_hz / rate_hz;
    endfunction

endpackage

// File: rtl/ledwire_bit_timer.sv
// Module ledwire_bit_timer
// Counts cycles from the most recent rising edge of the data line.
// Flags the end of the high phase and the end of the bit period, for the selected rate and bit value.
// Assumes high-time limits are strictly below the period and every limit is at least 1.
module ledwire_bit_timer #(
    parameter int unsigned CNT_W    = 7,
    parameter int unsigned FAST_PER = 60,
    parameter int unsigned FAST_T0  = 12,
    parameter int unsigned FAST_T1  = 38,
    parameter int unsigned SLOW_PER = 120,
    parameter int unsigned SLOW_T0  = 24,
    parameter int unsigned SLOW_T1  = 57
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic slow,
    input  logic bit_val,
    output logic hi_end,
    output logic per_end
);
    localparam logic [CNT_W-1:0] FP_LIM  = CNT_W'(FAST_PER - 1);
    localparam logic [CNT_W-1:0] F0_LIM  = CNT_W'(FAST_T0 - 1);
    localparam logic [CNT_W-1:0] F1_LIM  = CNT_W'(FAST_T1 - 1);
    localparam logic [CNT_W-1:0] SP_LIM  = CNT_W'(SLOW_PER - 1);
    localparam logic [CNT_W-1:0] S0_LIM  = CNT_W'(SLOW_T0 - 1);
    localparam logic [CNT_W-1:0] S1_LIM  = CNT_W'(SLOW_T1 - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_lim;
    logic [CNT_W-1:0] hi_lim;

    // Select the limits for the active rate and bit value.
    always_comb begin
        per_lim = slow ? SP_LIM : FP_LIM;
        if (slow) hi_lim = bit_val ? S1_LIM : S0_LIM;
        else      hi_lim = bit_val ? F1_LIM : F0_LIM;
    end

    // Cycle counter: zero at each rising edge, counts while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    assign hi_end  = run && (cnt == hi_lim);
    assign per_end = run && (cnt == per_lim);

    AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= per_lim)); // R6

endmodule

// File: rtl/ledwire_byte_seq.sv
// Module ledwire_byte_seq
// Holds the byte being sent and walks its bits from the most-significant end.
// Fetches the next byte at the edge where the final bit of the current byte starts.
// Reports the frame end, and flags an underrun when a needed byte is absent.
// Assumes 'advance' pulses once per completed bit period while a frame runs.
module ledwire_byte_seq #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              advance,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              fetch_ready,
    output logic              cur_bit,
    output logic              frame_end,
    output logic              underrun
);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic              cur_last;
    logic [DATA_W-1:0] nxt_data;
    logic              nxt_last;
    logic              nxt_ok;

    assign fetch_ready = advance && (bit_idx == IDX_W'(1)) && !cur_last;
    assign frame_end   = advance && (bit_idx == '0) && !nxt_ok;
    assign cur_bit     = shreg[DATA_W-1];

    // Shift, fetch and byte-swap sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_idx  <= '0;
            cur_last <= 1'b0;
            nxt_data <= '0;
            nxt_last <= 1'b0;
            nxt_ok   <= 1'b0;
            underrun <= 1'b0;
        end else if (load_first) begin
            shreg    <= in_data;
            bit_idx  <= IDX_TOP;
            cur_last <= in_last;
            nxt_ok   <= 1'b0;
            underrun <= 1'b0;
        end else if (advance) begin
            if (bit_idx != '0) begin
                shreg   <= {shreg[DATA_W-2:0], 1'b0};
                bit_idx <= bit_idx - 1'b1;
                if (fetch_ready) begin
                    if (in_valid) begin
                        nxt_data <= in_data;
                        nxt_last <= in_last;
                        nxt_ok   <= 1'b1;
                    end else begin
                        underrun <= 1'b1;
                    end
                end
            end else if (nxt_ok) begin
                shreg    <= nxt_data;
                cur_last <= nxt_last;
                bit_idx  <= IDX_TOP;
                nxt_ok   <= 1'b0;
            end
        end
    end

    AST_HELD_BYTE_ONLY_IN_FINAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_ok |-> (bit_idx == '0)); // R7
    AST_UNDERRUN_ONLY_OPEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> !cur_last); // R10

endmodule

// File: rtl/ledwire_encoder.sv
// Module ledwire_encoder
// Top level of the dual-rate single-wire LED encoder.
// Takes bytes over a valid/ready handshake and drives the pulse-width data line.
// Gives busy, a one-cycle done pulse and an underrun flag.
// Assumes a synchronous active-low reset and a rate input that is static per frame.
module ledwire_encoder
    import ledwire_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 48_000_000,
    parameter int unsigned FAST_HZ    = 800_000,
    parameter int unsigned FAST_T0_HZ = 4_000_000,
    parameter int unsigned FAST_T1_HZ = 1_250_000,
    parameter int unsigned SLOW_HZ    = 400_000,
    parameter int unsigned SLOW_T0_HZ = 2_000_000,
    parameter int unsigned SLOW_T1_HZ = 833_333,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_slow,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              line_out,
    output logic              busy,
    output logic              done,
    output logic              underrun
);
    localparam int unsigned FAST_PER = cycles_for(CLK_HZ, FAST_HZ);
    localparam int unsigned FAST_T0  = cycles_for(CLK_HZ, FAST_T0_HZ);
    localparam int unsigned FAST_T1  = cycles_for(CLK_HZ, FAST_T1_HZ);
    localparam int unsigned SLOW_PER = cycles_for(CLK_HZ, SLOW_HZ);
    localparam int unsigned SLOW_T0  = cycles_for(CLK_HZ, SLOW_T0_HZ);
    localparam int unsigned SLOW_T1  = cycles_for(CLK_HZ, SLOW_T1_HZ);
    localparam int unsigned MAX_PER  = (FAST_PER > SLOW_PER) ? FAST_PER : SLOW_PER;
    localparam int unsigned CNT_W    = $clog2(MAX_PER);

    enc_state_t state;
    logic       rate_q;
    logic       line_q;
    logic       done_q;
    logic       idle;
    logic       load_first;
    logic       bit_start;
    logic       hi_end;
    logic       per_end;
    logic       fetch_ready;
    logic       cur_bit;
    logic       frame_end;

    assign idle       = (state == ST_IDLE);
    assign load_first = idle && in_valid;
    assign bit_start  = load_first || (per_end && !frame_end);
    assign in_ready   = idle || fetch_ready;
    assign line_out   = line_q;
    assign busy       = (state == ST_SEND);
    assign done       = done_q;

    ledwire_bit_timer #(
        .CNT_W    (CNT_W),
        .FAST_PER (FAST_PER),
        .FAST_T0  (FAST_T0),
        .FAST_T1  (FAST_T1),
        .SLOW_PER (SLOW_PER),
        .SLOW_T0  (SLOW_T0),
        .SLOW_T1  (SLOW_T1)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (bit_start),
        .run     (busy),
        .slow    (rate_q),
        .bit_val (cur_bit),
        .hi_end  (hi_end),
        .per_end (per_end)
    );

    ledwire_byte_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_first  (load_first),
        .advance     (per_end),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .fetch_ready (fetch_ready),
        .cur_bit     (cur_bit),
        .frame_end   (frame_end),
        .underrun    (underrun)
    );

    // Frame state, latched rate, data line and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rate_q <= 1'b0;
            line_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state  <= ST_SEND;
                        rate_q <= rate_slow;
                        line_q <= 1'b1;
                    end
                end
                ST_SEND: begin
                    if (per_end) begin
                        if (frame_end) begin
                            state  <= ST_IDLE;
                            line_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            line_q <= 1'b1;
                        end
                    end else if (hi_end) begin
                        line_q <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !line_q); // R1
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8
    AST_RATE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEND) && $past(state == ST_SEND)) |-> $stable(rate_q)); // R9
    AST_FETCH_THEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_ready) |=> line_q); // R7

endmodule

// File: tb/test_ledwire_encoder.sv
module test_ledwire_encoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rate_slow;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_last;
    logic       in_ready;
    logic       line_out;
    logic       busy;
    logic       done;
    logic       underrun;

    always #2 clk = ~clk;

    ledwire_encoder i_ledwire_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_slow (rate_slow),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .line_out  (line_out),
        .busy      (busy),
        .done      (done),
        .underrun  (underrun)
    );

    int errors = 0;
    int checks = 0;

    // Vector format: {slow, byte count, three bytes, first byte in the top bits}
    localparam logic [26:0] VEC [6] = '{
        {1'b0, 2'd1, 24'hA50000},
        {1'b0, 2'd2, 24'h00FF00},
        {1'b1, 2'd1, 24'h3C0000},
        {1'b1, 2'd3, 24'h817E55},
        {1'b0, 2'd3, 24'hFF00C3},
        {1'b1, 2'd2, 24'h018000}
    };

    // Waveform monitor, sampled on the falling edge
    int   cyc = 0;
    int   rise_t [32];
    int   hi_len [32];
    int   rdy_t  [4];
    int   nr, nf, nrdy, ndone, done_t, acc_t, idle_rise;
    logic prev_line = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (line_out && !prev_line && nr < 32) begin
            rise_t[nr] = cyc;
            nr++;
            if (!busy) idle_rise++;
        end
        if (!line_out && prev_line && nf < nr) begin
            hi_len[nf] = cyc - rise_t[nf];
            nf++;
        end
        if (done) begin
            done_t = cyc;
            ndone++;
        end
        if (busy && in_ready && nrdy < 4) begin
            rdy_t[nrdy] = cyc;
            nrdy++;
        end
        if (!busy && in_ready && in_valid) acc_t = cyc;
        prev_line = line_out;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nr = 0; nf = 0; nrdy = 0; ndone = 0; done_t = 0; acc_t = 0; idle_rise = 0;
    endtask

    // Drive one frame; flip changes the rate after byte 0, starve leaves byte 0 open
    task automatic run_frame(input bit slow, input int nb, input logic [23:0] bytes,
                             input bit flip, input bit starve);
        @(posedge clk); #1;
        clear_mon();
        rate_slow = slow;
        for (int b = 0; b < nb; b++) begin
            in_data  = bytes[23 - 8*b -: 8];
            in_valid = 1'b1;
            in_last  = (b == nb - 1) && !starve;
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
            if (flip && b == 0) rate_slow = !slow;
        end
        while (ndone == 0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic verify(input bit slow, input int nb, input logic [23:0] bytes,
                          input bit flip, input bit starve);
        int per, t0, t1;
        per = slow ? 120 : 60;
        t0  = slow ? 24 : 12;
        t1  = slow ? 57 : 38;
        chk(nr == 8*nb, "R4 bit count", nr, 8*nb);
        chk(rise_t[0] - acc_t == 1, "R5 first rise after accept", rise_t[0] - acc_t, 1);
        for (int i = 0; i < nr && i < 8*nb; i++) begin
            int e;
            e = bytes[23 - i] ? t1 : t0;
            if (slow) chk(hi_len[i] == e, "R3 R4 high time", hi_len[i], e);
            else      chk(hi_len[i] == e, "R2 R4 high time", hi_len[i], e);
        end
        for (int i = 1; i < nr; i++) begin
            if (flip) chk(rise_t[i] - rise_t[i-1] == per, "R9 period under rate change",
                          rise_t[i] - rise_t[i-1], per);
            else      chk(rise_t[i] - rise_t[i-1] == per, "R6 rise spacing",
                          rise_t[i] - rise_t[i-1], per);
        end
        chk(ndone == 1, "R8 done pulse count", ndone, 1);
        chk(done_t - rise_t[nr-1] == per, "R8 done timing", done_t - rise_t[nr-1], per);
        chk(busy == 1'b0, "R8 busy low after done", busy, 0);
        chk(idle_rise == 0, "R8 busy at every rise", idle_rise, 0);
        chk(nrdy == (starve ? 1 : nb - 1), "R7 ready pulses", nrdy, starve ? 1 : nb - 1);
        for (int k = 0; k < nrdy; k++)
            chk(rdy_t[k] == rise_t[8*k + 7] - 1, "R7 ready slot", rdy_t[k], rise_t[8*k + 7] - 1);
        chk(underrun == starve, "R10 underrun flag", underrun, starve);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R8: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rate_slow = 1'b0; in_data = '0; in_valid = 1'b0; in_last = 1'b0;
        clear_mon();
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(line_out == 1'b0, "R1 line after reset", line_out, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            run_frame(VEC[v][26], int'(VEC[v][25:24]), VEC[v][23:0], 1'b0, 1'b0);
            verify(VEC[v][26], int'(VEC[v][25:24]), VEC[v][23:0], 1'b0, 1'b0);
            chk(line_out == 1'b0, "R1 line idle between frames", line_out, 0);
        end

        // R9 rate input toggled right after the first byte
        run_frame(1'b0, 2, 24'hC3A500, 1'b1, 1'b0);
        verify(1'b0, 2, 24'hC3A500, 1'b1, 1'b0);

        // R10 byte 0 left open, nothing further offered
        run_frame(1'b0, 1, 24'hC50000, 1'b0, 1'b1);
        verify(1'b0, 1, 24'hC50000, 1'b0, 1'b1);
        chk(line_out == 1'b0, "R10 line low after underrun", line_out, 0);
        repeat (5) @(posedge clk); #1;
        chk(underrun == 1'b1, "R10 flag held while idle", underrun, 1);
        // R10 flag clears once a new frame starts
        run_frame(1'b1, 1, 24'h5A0000, 1'b0, 1'b0);
        verify(1'b1, 1, 24'h5A0000, 1'b0, 1'b0);

        // R1 reset in the middle of a frame
        @(posedge clk); #1;
        rate_slow = 1'b0; in_data = 8'hFF; in_valid = 1'b1; in_last = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (20) @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_out == 1'b0, "R1 line after mid-frame reset", line_out, 0);
        chk(busy == 1'b0, "R1 busy after mid-frame reset", busy, 0);
        chk(in_ready == 1'b1, "R1 ready after mid-frame reset", in_ready, 1);
        repeat (100) @(negedge clk);
        chk(line_out == 1'b0, "R1 line stays low when idle", line_out, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule